// File: doc/BRIEF.md
# Frequency-Offset to Step-Trim Converter

This unit turns a requested clock-rate correction into the signed fractional-nanosecond trim that a time-of-day counter adds to its step. The request is a signed rate offset in parts per million with 16 fractional bits. It is taken with the counter's nominal step period, a 32.32 fixed-point nanosecond value. The unit works in the period domain. A clock that must run faster by a fraction f needs its period shortened by `period * f / (1 + f)`. So it forms `period * |ppm|` and divides it by `2^16 * 10^6 + |ppm|`. To keep the operands narrow, both are first divided by 16 through a right shift. This gives a dividend of `(period * |ppm|) >> 4` and a divisor of `(10^6 << 12) + (|ppm| >> 4)`.

The division is bit-serial, one quotient bit per clock. After the last bit the unit restores the sign of the request and limits the magnitude to the signed 32-bit range. The limit is asymmetric: a negative result may reach -2^31, and a positive result stops at 2^31-1. A single-cycle `start` launches a conversion. A single-cycle `done` marks the new trim, which then stays on the output until the next conversion finishes.

Top module: `ppm_step_trim`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `trim` is 0.
- R2: With m = |ppm| (ppm read as two's complement), the magnitude q equals floor(((period * m) >> 4) / (4096000000 + (m >> 4))), computed without loss of bits.
- R3: When ppm bit 31 is 0, trim = +q. When it is 1, trim = -q in two's complement, as long as no limit applies.
- R4: When ppm is non-negative and q exceeds 0x7FFFFFFF, trim is 0x7FFFFFFF.
- R5: When ppm is negative and q exceeds 0x80000000, q is first replaced by 0x80000000. trim is then 0x80000000.
- R6: A start seen while `busy` is 0 is accepted at that clock edge. `busy` is 1 for the next 94 cycles. `done` is 1 for exactly one cycle, the 94th edge after acceptance, when `busy` returns to 0.
- R7: A start raised while `busy` is 1 is ignored. The running conversion completes with its original operands, and no further result follows from the ignored start.
- R8: `trim` changes only in a cycle where `done` is 1. Between results it holds its value whatever the inputs do.
- R9: A zero ppm request yields trim 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to convert the current operands |
| period | input | 64 | Nominal step period, 32.32 fixed-point ns |
| ppm | input | 32 | Signed rate offset, ppm with 16 fraction bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: new trim valid |
| trim | output | 32 | Signed fractional-step trim, held between results |

## Verification
The bench builds the unit with its default widths: a 64-bit period, a 32-bit request, a 32-bit trim and a prescale of 4. These give a 93-bit dividend and a 94-cycle conversion. With these values, a period of 2^31 x 4096000001 combined with a request of plus or minus 16 gives a divisor of exactly 4096000001. This lands the quotient exactly on 2^31, or one step to either side of it. Both saturation edges and the asymmetric negative clamp can then be hit exactly. Large-period vectors drive the quotient far past the limit, and the most negative request checks the absolute-value path.

// File: rtl/ppmtrim_pkg.sv
package ppmtrim_pkg;

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

    localparam int PPM_UNIT_DEF = 1000000;

endpackage

// File: rtl/ppmtrim_operands.sv
module ppmtrim_operands
    import ppmtrim_pkg::*;
#(
    parameter int PER_W     = 64,
    parameter int PPM_W     = 32,
    parameter int PRESCALE  = 4,
    parameter int FRAC_BITS = 16,
    parameter int PPM_UNIT  = PPM_UNIT_DEF,
    parameter int DEN_W     = PPM_W + 8,
    parameter int NUM_W     = PER_W + PPM_W + 1 - PRESCALE
) (
    input  logic [PER_W-1:0] period,
    input  logic [PPM_W-1:0] ppm,
    output logic [NUM_W-1:0] num,
    output logic [DEN_W-1:0] den,
    output sign_e            sign
);

    localparam int PROD_W = PER_W + PPM_W + 1;
    localparam logic [DEN_W-1:0] BASE = DEN_W'(PPM_UNIT) << (FRAC_BITS - PRESCALE);

    logic [PPM_W:0]    mag;
    logic [PROD_W-1:0] prod;

    always_comb begin
        sign = ppm[PPM_W-1] ? SIGN_NEG : SIGN_POS;
        if (sign == SIGN_NEG) begin
            mag = ~{ppm[PPM_W-1], ppm} + 1'b1;
        end else begin
            mag = {1'b0, ppm};
        end
        prod = {{(PPM_W+1){1'b0}}, period} * {{PER_W{1'b0}}, mag};
        num  = prod[PROD_W-1:PRESCALE];
        den  = BASE + {{(DEN_W-PPM_W-1+PRESCALE){1'b0}}, mag[PPM_W:PRESCALE]};
    end

endmodule

// File: rtl/ppmtrim_divider.sv
module ppmtrim_divider #(
    parameter int NUM_W = 93,
    parameter int DEN_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             busy,
    output logic             vld
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [NUM_W-1:0] work;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             vld;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           qbit;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        trial    = {st_q.rem, st_q.work[NUM_W-1]};
        diff     = trial - {1'b0, st_q.den};
        qbit     = (trial >= {1'b0, st_q.den});
        if (load) begin
            st_d.work = num;
            st_d.rem  = '0;
            st_d.den  = den;
            st_d.cnt  = CNT_W'(NUM_W);
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            st_d.rem  = qbit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            st_d.work = {st_q.work[NUM_W-2:0], qbit};
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quo  = st_q.work;
    assign busy = st_q.busy;
    assign vld  = st_q.vld;

    // R2
    rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.rem < st_q.den));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !load) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R7
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !st_q.busy);

endmodule

// File: rtl/ppmtrim_saturate.sv
module ppmtrim_saturate
    import ppmtrim_pkg::*;
#(
    parameter int NUM_W  = 93,
    parameter int TRIM_W = 32
) (
    input  logic [NUM_W-1:0]  quo,
    input  sign_e             sign,
    output logic [TRIM_W-1:0] trim
);

    localparam logic [NUM_W-1:0] POS_LIM =
        {{(NUM_W-TRIM_W){1'b0}}, 1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic [NUM_W-1:0] NEG_LIM =
        {{(NUM_W-TRIM_W){1'b0}}, 1'b1, {(TRIM_W-1){1'b0}}};

    logic [TRIM_W-1:0] mag_lim;

    always_comb begin
        if (sign == SIGN_NEG) begin
            mag_lim = (quo > NEG_LIM) ? NEG_LIM[TRIM_W-1:0] : quo[TRIM_W-1:0];
            trim    = ~mag_lim + 1'b1;
        end else begin
            mag_lim = (quo > POS_LIM) ? POS_LIM[TRIM_W-1:0] : quo[TRIM_W-1:0];
            trim    = mag_lim;
        end
    end

endmodule

// File: rtl/ppm_step_trim.sv
module ppm_step_trim
    import ppmtrim_pkg::*;
#(
    parameter int PER_W     = 64,
    parameter int PPM_W     = 32,
    parameter int TRIM_W    = 32,
    parameter int PRESCALE  = 4,
    parameter int FRAC_BITS = 16,
    parameter int PPM_UNIT  = PPM_UNIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PER_W-1:0]  period,
    input  logic [PPM_W-1:0]  ppm,
    output logic              busy,
    output logic              done,
    output logic [TRIM_W-1:0] trim
);

    localparam int NUM_W = PER_W + PPM_W + 1 - PRESCALE;
    localparam int DEN_W = PPM_W + 8;

    typedef struct packed {
        logic              busy;
        logic              done;
        sign_e             sign;
        logic [TRIM_W-1:0] trim;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_W-1:0]  op_num;
    logic [DEN_W-1:0]  op_den;
    sign_e             op_sign;
    logic [NUM_W-1:0]  div_quo;
    logic              div_busy;
    logic              div_vld;
    logic [TRIM_W-1:0] sat_trim;
    logic              accept;

    ppmtrim_operands #(
        .PER_W     (PER_W),
        .PPM_W     (PPM_W),
        .PRESCALE  (PRESCALE),
        .FRAC_BITS (FRAC_BITS),
        .PPM_UNIT  (PPM_UNIT),
        .DEN_W     (DEN_W),
        .NUM_W     (NUM_W)
    ) u_operands (
        .period (period),
        .ppm    (ppm),
        .num    (op_num),
        .den    (op_den),
        .sign   (op_sign)
    );

    ppmtrim_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_divider (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .num   (op_num),
        .den   (op_den),
        .quo   (div_quo),
        .busy  (div_busy),
        .vld   (div_vld)
    );

    ppmtrim_saturate #(
        .NUM_W  (NUM_W),
        .TRIM_W (TRIM_W)
    ) u_saturate (
        .quo  (div_quo),
        .sign (st_q.sign),
        .trim (sat_trim)
    );

    assign accept = start && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.sign = op_sign;
        end else if (div_vld) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.trim = sat_trim;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, sign: SIGN_POS, trim: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign trim = st_q.trim;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    busy_covers_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy);

    // R8
    trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(trim));

    // R4
    pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.sign == SIGN_POS) |-> !trim[TRIM_W-1]);

    // R5
    neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.sign == SIGN_NEG) |-> (trim[TRIM_W-1] || trim == '0));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.sign));

endmodule

// File: tb/ppm_step_trim_tb.sv
module ppm_step_trim_tb;

    localparam int NCYC = 64 + 32 + 1 - 4;
    localparam logic [63:0] PB = 64'd4096000001 << 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] period = '0;
    logic [31:0] ppm = '0;
    logic        busy;
    logic        done;
    logic [31:0] trim;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic [31:0] m_trim = '0;
    logic [31:0] m_pend = '0;

    always #2.5 clk = ~clk;

    ppm_step_trim u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .period (period),
        .ppm    (ppm),
        .busy   (busy),
        .done   (done),
        .trim   (trim)
    );

    function automatic logic [31:0] ref_trim(input logic [63:0] p, input logic [31:0] s);
        logic [127:0] m, nm, dn, q;
        m  = s[31] ? (128'd0 - {{96{1'b1}}, s}) : {96'd0, s};
        nm = ({64'd0, p} * m) >> 4;
        dn = 128'd4096000000 + (m >> 4);
        q  = nm / dn;
        if (s[31]) begin
            if (q > 128'h8000_0000) q = 128'h8000_0000;
            return 32'd0 - q[31:0];
        end
        if (q > 128'h7FFF_FFFF) q = 128'h7FFF_FFFF;
        return q[31:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_done = 1'b0;
            m_trim = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_trim = m_pend;
                    m_done = 1'b1;
                end
            end else if (start) begin
                m_cnt  = NCYC + 1;
                m_pend = ref_trim(period, ppm);
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1", "busy in reset", {31'd0, busy}, 32'd0);
            check("R1", "done in reset", {31'd0, done}, 32'd0);
            check("R1", "trim in reset", trim, 32'd0);
        end else begin
            check("R6", "busy", {31'd0, busy}, {31'd0, (m_cnt != 0)});
            check("R6", "done", {31'd0, done}, {31'd0, m_done});
            check(m_done ? cur_req : "R8", "trim", trim, m_trim);
        end
    end

    task automatic run_op(input string req, input logic [63:0] p, input logic [31:0] s);
        cur_req = req;
        @(negedge clk);
        period = p;
        ppm    = s;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        period = ~p;
        ppm    = ~s;
        repeat (NCYC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: zero offset gives zero trim
        run_op("R9", 64'd3 << 32, 32'd0);
        // R3: +1 ppm and -1 ppm around a 3 ns period
        run_op("R3", 64'd3 << 32, 32'd65536);
        run_op("R3", 64'd3 << 32, 32'hFFFF_0000);
        // R2: largest positive and most negative request
        run_op("R2", 64'd3 << 32, 32'h7FFF_FFFF);
        run_op("R2", 64'd3 << 32, 32'h8000_0000);
        run_op("R2", 64'h0000_0008_1234_5678, 32'd1234567);
        // R4: quotient exactly 2^31 and far above, positive
        run_op("R4", PB, 32'd16);
        run_op("R4", 64'hFFFF_FFFF_FFFF_FFFF, 32'h4000_0000);
        run_op("R2", PB - 64'd1, 32'd16);
        // R5: quotient 2^31 and 2^31+1, negative
        run_op("R5", PB, 32'hFFFF_FFF0);
        run_op("R5", PB + 64'd4096000001, 32'hFFFF_FFF0);
        run_op("R5", 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000);
        run_op("R3", PB - 64'd1, 32'hFFFF_FFF0);
        // R7: a start during busy must not change the result
        cur_req = "R7";
        @(negedge clk);
        period = 64'd3 << 32;
        ppm    = 32'd655360;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (10) @(negedge clk);
        period = PB;
        ppm    = 32'hFFFF_FFF0;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (NCYC + 2) @(negedge clk);
        // R8: idle with changing inputs, trim must hold
        cur_req = "R8";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            period = {32'(i), 32'hA5A5_0000};
            ppm    = 32'(i * 7777);
        end
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule